// File: doc/BRIEF.md
# Outlier-Confirming Reference Tracker

This block sits between a phase detector and a clock-discipline loop filter. Each strobed signed phase-error reading is measured against a held reference offset. A reading whose distance from that reference is within a programmable limit goes straight to the loop. A single reading beyond the limit is not forwarded. Instead the block asks for a confirming re-measurement, so that one glitched sample cannot make the loop slew.

If the confirming reading is also beyond the limit, the block takes that reading as the new reference and forwards a zero error, so the loop holds rather than chasing. It also fires a re-reference pulse, sets a sticky poor-sync flag for an operator and bumps a saturating event count. While an operator override is asserted, the automatic decision is suspended and readings reach the loop unfiltered.

Top module: `ref_outlier_guard`

## Requirements
- R1: After a synchronous reset, out_valid, remeasure_req, reanchor_pulse and notify_flag are low, out_err and reanchor_count are zero, the reference offset is zero and the block is tracking.
- R2: In the tracking state, a strobed reading whose relative error (reading minus reference, 17-bit signed) has magnitude at most `limit` appears one clock later on out_err, with out_valid high for exactly that cycle. A magnitude equal to `limit` counts as in range.
- R3: In the tracking state, a reading whose relative-error magnitude exceeds `limit` is not forwarded. out_valid stays low, remeasure_req pulses high for one cycle, and the block waits for confirmation.
- R4: While waiting for confirmation, an in-range reading is forwarded as in R2 and the block returns to tracking.
- R5: While waiting for confirmation, an out-of-range reading becomes the new reference offset. One clock later out_valid is high with out_err equal to zero and reanchor_pulse is high for one cycle.
- R6: Readings after a re-reference are forwarded and judged relative to the new offset.
- R7: notify_flag is set by every re-reference and stays set until notify_clr is high at a clock edge with no re-reference at that same edge. A re-reference wins over a simultaneous clear.
- R8: reanchor_count (4 bits by default) increments on each re-reference and stays at its maximum (15) once reached.
- R9: A reading strobed with override high is forwarded unchanged as its relative error, whatever its size. It issues no re-measure request and no re-reference, and cancels any pending confirmation.
- R10: A cycle without meas_valid forwards nothing, requests nothing and leaves the reference and state unchanged, whatever the value on meas_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Strobe for meas_err |
| meas_err | input | ERR_W (16) | Signed phase-error reading |
| limit | input | ERR_W (16) | Unsigned outlier threshold |
| override | input | 1 | Operator override; suspends automatic filtering |
| notify_clr | input | 1 | Write-one-to-clear for notify_flag |
| out_valid | output | 1 | Strobe for out_err |
| out_err | output | ERR_W+1 (17) | Signed error forwarded to the loop |
| remeasure_req | output | 1 | One-cycle request for a confirming reading |
| reanchor_pulse | output | 1 | One-cycle pulse when the reference is re-anchored |
| notify_flag | output | 1 | Sticky poor-sync notification |
| reanchor_count | output | CNT_W (4) | Saturating count of re-anchor events |

## Verification
The embedded properties check every cycle that a re-reference comes only out of the confirmation state and carries a zero forwarded error. They also check that it always leaves the flag set, that requests and re-references never occur under override or without a strobe, and that the counter only steps by one and never wraps. The exact forwarded values, the boundary at magnitude equal to the limit, the relative measurement after the reference moves, cancellation of a pending confirmation by override, and clear-versus-set ordering can only be shown by the bench scenarios against its behavioural model.

// File: rtl/ref_guard_pkg.sv
package ref_guard_pkg;
  typedef enum logic [1:0] {
    ST_TRACK    = 2'd0,
    ST_CONFIRM  = 2'd1,
    ST_REANCHOR = 2'd2
  } guard_state_t;
endpackage

// File: rtl/outlier_detect.sv
// Relative error against the held reference, and the out-of-range decision.
module outlier_detect #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] meas,
  input  logic signed [ERR_W-1:0] ref_off,
  input  logic        [ERR_W-1:0] limit,
  output logic signed [ERR_W:0]   rel,
  output logic                    outlier
);
  logic [ERR_W:0] mag;

  always_comb begin
    rel = {meas[ERR_W-1], meas} - {ref_off[ERR_W-1], ref_off};
    mag = rel[ERR_W] ? (~rel + 1'b1) : rel;
    outlier = (mag > {1'b0, limit});
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != MAX)
      count <= count + 1'b1;
  end

  // R8: once at maximum, the counter stays there
  a_r8_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (count == MAX) |=> (count == MAX));
  // R8: any change is a single upward step
  a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7: a set always lands, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
endmodule

// File: rtl/ref_outlier_guard.sv
module ref_outlier_guard
  import ref_guard_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    meas_valid,
  input  logic signed [ERR_W-1:0] meas_err,
  input  logic        [ERR_W-1:0] limit,
  input  logic                    override,
  input  logic                    notify_clr,
  output logic                    out_valid,
  output logic signed [ERR_W:0]   out_err,
  output logic                    remeasure_req,
  output logic                    reanchor_pulse,
  output logic                    notify_flag,
  output logic [CNT_W-1:0]        reanchor_count
);
  guard_state_t               state;
  logic signed [ERR_W-1:0]    ref_off;
  logic signed [ERR_W:0]      rel;
  logic                       outlier;
  logic                       anchor_now;

  outlier_detect #(.ERR_W(ERR_W)) u_detect (
    .meas    (meas_err),
    .ref_off (ref_off),
    .limit   (limit),
    .rel     (rel),
    .outlier (outlier)
  );

  assign anchor_now = meas_valid && !override && (state == ST_CONFIRM) && outlier;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_TRACK;
      ref_off        <= '0;
      out_valid      <= 1'b0;
      out_err        <= '0;
      remeasure_req  <= 1'b0;
      reanchor_pulse <= 1'b0;
    end else begin
      out_valid      <= 1'b0;
      remeasure_req  <= 1'b0;
      reanchor_pulse <= 1'b0;
      if (state == ST_REANCHOR)
        state <= ST_TRACK;
      if (meas_valid) begin
        if (override) begin
          out_valid <= 1'b1;
          out_err   <= rel;
          state     <= ST_TRACK;
        end else if (state == ST_CONFIRM) begin
          if (outlier) begin
            ref_off        <= meas_err;
            out_valid      <= 1'b1;
            out_err        <= '0;
            reanchor_pulse <= 1'b1;
            state          <= ST_REANCHOR;
          end else begin
            out_valid <= 1'b1;
            out_err   <= rel;
            state     <= ST_TRACK;
          end
        end else begin
          if (outlier) begin
            remeasure_req <= 1'b1;
            state         <= ST_CONFIRM;
          end else begin
            out_valid <= 1'b1;
            out_err   <= rel;
          end
        end
      end
    end
  end

  sticky_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (anchor_now),
    .clr  (notify_clr),
    .flag (notify_flag)
  );

  sat_counter #(.W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .inc   (anchor_now),
    .count (reanchor_count)
  );

  // R3: a request is never paired with a forwarded value
  a_r3_req_no_forward: assert property (@(posedge clk) disable iff (rst)
    remeasure_req |-> (!out_valid && !reanchor_pulse));
  // R5: a re-reference only follows a pending confirmation
  a_r5_from_confirm: assert property (@(posedge clk) disable iff (rst)
    reanchor_pulse |-> ($past(state) == ST_CONFIRM));
  // R5: a re-reference forwards zero error
  a_r5_zero_error: assert property (@(posedge clk) disable iff (rst)
    reanchor_pulse |-> (out_valid && out_err == '0));
  // R7: the notification is up whenever a re-reference is reported
  a_r7_flag_on_anchor: assert property (@(posedge clk) disable iff (rst)
    reanchor_pulse |-> notify_flag);
  // R9: override suppresses the automatic decisions
  a_r9_override_quiet: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && override) |=> (out_valid && !remeasure_req && !reanchor_pulse));
  // R10: no strobe, no activity
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> (!out_valid && !remeasure_req && !reanchor_pulse));
endmodule

// File: tb/ref_outlier_guard_test.sv
`timescale 1ns/1ps
module ref_outlier_guard_test;
  localparam int ERR_W   = 16;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic meas_valid = 1'b0;
  logic signed [ERR_W-1:0] meas_err = '0;
  logic [ERR_W-1:0] limit = 16'd100;
  logic override = 1'b0;
  logic notify_clr = 1'b0;
  logic out_valid;
  logic signed [ERR_W:0] out_err;
  logic remeasure_req, reanchor_pulse, notify_flag;
  logic [CNT_W-1:0] reanchor_count;

  always #4 clk = ~clk;  // 125 MHz

  ref_outlier_guard #(.ERR_W(ERR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_err(meas_err),
    .limit(limit), .override(override), .notify_clr(notify_clr),
    .out_valid(out_valid), .out_err(out_err), .remeasure_req(remeasure_req),
    .reanchor_pulse(reanchor_pulse), .notify_flag(notify_flag),
    .reanchor_count(reanchor_count)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference model
  int m_ref = 0, m_state = 0, m_cnt = 0;
  bit m_flag = 0, e_valid = 0, e_req = 0, e_pulse = 0;
  int e_err = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ref = 0; m_state = 0; m_cnt = 0; m_flag = 0;
      e_valid = 0; e_req = 0; e_pulse = 0; e_err = 0;
    end else begin
      bit anchor;
      int rel, mag;
      anchor = 0;
      e_valid = 0; e_req = 0; e_pulse = 0;
      if (m_state == 2) m_state = 0;
      if (meas_valid) begin
        rel = int'(meas_err) - m_ref;
        mag = (rel < 0) ? -rel : rel;
        if (override) begin
          e_valid = 1; e_err = rel; m_state = 0;
        end else if (m_state == 1) begin
          if (mag > int'(limit)) begin
            m_ref = int'(meas_err); e_valid = 1; e_err = 0; e_pulse = 1;
            m_state = 2; anchor = 1;
          end else begin
            e_valid = 1; e_err = rel; m_state = 0;
          end
        end else if (mag > int'(limit)) begin
          e_req = 1; m_state = 1;
        end else begin
          e_valid = 1; e_err = rel;
        end
      end
      if (anchor) m_flag = 1;
      else if (notify_clr) m_flag = 0;
      if (anchor && m_cnt < CNT_MAX) m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== e_valid || int'(out_err) != e_err ||
          remeasure_req !== e_req || reanchor_pulse !== e_pulse ||
          notify_flag !== m_flag || int'(reanchor_count) != m_cnt) begin
        failures++;
        $display("FAIL %s: got v=%0b err=%0d req=%0b pulse=%0b flag=%0b cnt=%0d exp v=%0b err=%0d req=%0b pulse=%0b flag=%0b cnt=%0d",
          cur_req, out_valid, out_err, remeasure_req, reanchor_pulse, notify_flag,
          reanchor_count, e_valid, e_err, e_req, e_pulse, m_flag, m_cnt);
      end
    end
  end

  task automatic send(input int v, input bit ovr, input bit clr);
    @(negedge clk);
    meas_valid = 1'b1; meas_err = 16'(v); override = ovr; notify_clr = clr;
    @(negedge clk);
    meas_valid = 1'b0; override = 1'b0; notify_clr = 1'b0;
    meas_err = 16'h5A5A;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      meas_err = 16'(i * 7919);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);
    cur_req = "R2"; send(50, 0, 0); send(-100, 0, 0); send(100, 0, 0); send(0, 0, 0);
    cur_req = "R3"; send(101, 0, 0); idle(1);
    cur_req = "R4"; send(20, 0, 0); send(-101, 0, 0); send(-99, 0, 0);
    cur_req = "R5"; send(500, 0, 0); send(520, 0, 0); idle(1);
    cur_req = "R6"; send(530, 0, 0); send(400, 0, 0); send(525, 0, 0); send(620, 0, 0);
    cur_req = "R10"; meas_valid = 1'b0; idle(5);
    cur_req = "R7"; notify_clr = 1'b1; idle(1); notify_clr = 1'b0; idle(2);
    send(0, 0, 0); send(10, 0, 1); idle(2);
    notify_clr = 1'b1; idle(1); notify_clr = 1'b0;
    cur_req = "R9"; send(5000, 1, 0); send(-20000, 0, 0); send(-20000, 1, 0);
    send(90, 0, 0); send(32767, 1, 0);
    send(-32768, 0, 0); send(-32768, 0, 0); idle(1);
    cur_req = "R8";
    for (int k = 0; k < 18; k++) begin
      send((k % 2) ? 3000 : -3000, 0, 0);
      send((k % 2) ? 3000 : -3000, 0, 0);
    end
    idle(3);
    cur_req = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule